// File: doc/BRIEF.md
# Timer Overflow Status and Control Word

This block is the single control and status word of a free-running timer. A modulo up-counter with a power-of-two prescaler is included, so the block produces its own overflow events. Each overflow sets a sticky flag. The flag can raise an interrupt request, a DMA request, or both, depending on two enable bits. The same word also holds a clock mode field, which starts or stops the counter, and a prescaler field, which sets the count rate.

Software reaches the word through a simple single-cycle port at offset 0. Writes land on the next clock edge, and reads return the live value in the same cycle. The flag is cleared by writing a one to its bit. A hidden second-overflow bit makes sure that an overflow arriving before software clears the flag is not lost. In that case the first clearing write is absorbed, and the flag stays set until a later clearing write.

Top module: `tmr_ctrl_reg`

## Requirements
- R1: After reset, every field reads 0, the counter output is 0, and both request outputs are low.
- R2: Bits 31 to 9 and bit 5 always read 0, and writing ones to them has no effect.
- R3: A write at offset 0 updates the following fields at the next clock edge, and a read at offset 0 returns them:
  - DMA enable at bit 8
  - interrupt enable at bit 6
  - clock mode at bits 4:3
  - prescaler at bits 2:0
- R4: Clock mode 0 holds the counter still. Any non-zero clock mode makes it count on the internal clock.
- R5: While running, the counter advances once every 2^P cycles, where P is the prescaler value. The interval between two consecutive wraps to zero is therefore (M+1)*2^P cycles, where M is the modulo input.
- R6: When the counter advances while at or above the modulo value, it wraps to 0. The overflow flag (bit 7) becomes 1 at that same clock edge.
- R7: Writing 1 to bit 7 clears the overflow flag. Writing 0 to bit 7 leaves the flag unchanged.
- R8: If a second overflow occurs while the flag is already set, the next write of 1 to bit 7 leaves the flag set. The write after that clears it.
- R9: If an overflow and a write of 1 to bit 7 fall in the same cycle, the flag is 1 afterwards.
- R10: The interrupt request is high exactly when the flag and the interrupt enable are both 1.
- R11: The DMA request is high exactly when the flag and the DMA enable are both 1.
- R12: Accesses at any non-zero offset leave the word unchanged and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 unless this is a read at offset 0 |
| mod_val | input | CNT_W | Modulo value at which the counter wraps |
| cnt_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Overflow interrupt request |
| dma_req_o | output | 1 | Overflow DMA request |

## Verification
The assertions check on every cycle that:
- the reserved bits stay zero;
- each wrap of the counter to zero coincides with a set flag;
- the flag falls only after a clearing write, and never while a second overflow is pending;
- a stopped counter holds its value;
- both request outputs track the flag and their enables.

Only the directed scenarios can show the following:
- the exact wrap interval for a given prescaler and modulo;
- that a clearing write issued alongside an overflow is overridden;
- that two writes are needed after a double overflow;
- that off-offset accesses change nothing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int PS_W     = 3;
    localparam int CM_W     = 2;
    localparam int B_PS_LO  = 0;
    localparam int B_CM_LO  = 3;
    localparam int B_RSV5   = 5;
    localparam int B_IE     = 6;
    localparam int B_FLAG   = 7;
    localparam int B_DMA    = 8;
    localparam int USED_TOP = B_DMA;

    typedef struct packed {
        logic            dma_en;
        logic            irq_en;
        logic [CM_W-1:0] clk_mode;
        logic [PS_W-1:0] pscale;
    } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_fields.sv
module tmr_ctrl_fields
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.dma_en   = wdata[B_DMA];
            ctrl_d.irq_en   = wdata[B_IE];
            ctrl_d.clk_mode = wdata[B_CM_LO +: CM_W];
            ctrl_d.pscale   = wdata[B_PS_LO +: PS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  pscale,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [PRE_W-1:0] pre_mask;
    logic             tick;

    always_comb begin
        pre_mask = ~({PRE_W{1'b1}} << pscale);
        tick     = run && ((st_q.pre & pre_mask) == pre_mask);
        ovf_o    = tick && (st_q.cnt >= mod_val);
        st_d     = st_q;
        if (run) st_d.pre = st_q.pre + 1'b1;
        if (tick) begin
            if (ovf_o) st_d.cnt = '0;
            else       st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic clr_i,
    output logic flag_o,
    output logic reovf_o
);
    typedef struct packed {
        logic flag;
        logic reovf;
    } flag_state_t;

    flag_state_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (ovf_i) begin
            fs_d.flag  = 1'b1;
            fs_d.reovf = fs_q.reovf | fs_q.flag;
        end else if (clr_i) begin
            if (fs_q.reovf) fs_d.reovf = 1'b0;
            else            fs_d.flag  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign flag_o  = fs_q.flag;
    assign reovf_o = fs_q.reovf;
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  mod_val,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o,
    output logic              dma_req_o
);
    logic        at_base, wr_hit, rd_hit, clr_req;
    logic        ovf_evt, flag, reovf, cnt_run;
    ctrl_t       ctrl;
    logic [31:0] reg_word;

    assign at_base = (bus_addr == '0);
    assign wr_hit  = bus_sel && bus_wr && at_base;
    assign rd_hit  = bus_sel && !bus_wr && at_base;
    assign clr_req = wr_hit && bus_wdata[B_FLAG];
    assign cnt_run = (ctrl.clk_mode != '0);

    tmr_ctrl_fields u_fields (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_hit),
        .wdata  (bus_wdata),
        .ctrl_o (ctrl)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_run),
        .pscale  (ctrl.pscale),
        .mod_val (mod_val),
        .cnt_o   (cnt_o),
        .ovf_o   (ovf_evt)
    );

    tmr_ovf_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_i   (ovf_evt),
        .clr_i   (clr_req),
        .flag_o  (flag),
        .reovf_o (reovf)
    );

    always_comb begin
        reg_word                     = '0;
        reg_word[B_DMA]              = ctrl.dma_en;
        reg_word[B_FLAG]             = flag;
        reg_word[B_IE]               = ctrl.irq_en;
        reg_word[B_CM_LO +: CM_W]    = ctrl.clk_mode;
        reg_word[B_PS_LO +: PS_W]    = ctrl.pscale;
    end

    assign bus_rdata = rd_hit ? reg_word : '0;
    assign irq_o     = flag && ctrl.irq_en;
    assign dma_req_o = flag && ctrl.dma_en;
endmodule

// File: rtl/tmr_ctrl_reg_chk.sv
module tmr_ctrl_reg_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_hit,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      reg_word,
    input logic [CNT_W-1:0] cnt_o,
    input logic             irq_o,
    input logic             dma_req_o,
    input logic             flag,
    input logic             reovf,
    input logic             cnt_run
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_word[31:9] == '0 && reg_word[5] == 1'b0);

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && $past(cnt_o) != '0) |-> flag);

    // R7
    flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_hit && bus_wdata[7]));

    // R8
    flag_fall_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> !$past(reovf));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_run) |-> $stable(cnt_o));

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (reg_word[7] && reg_word[6]));

    // R11
    dma_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o == (reg_word[7] && reg_word[8]));
endmodule

bind tmr_ctrl_reg tmr_ctrl_reg_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .bus_wdata (bus_wdata),
    .reg_word  (reg_word),
    .cnt_o     (cnt_o),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o),
    .flag      (flag),
    .reovf     (reovf),
    .cnt_run   (cnt_run)
);

// File: tb/tmr_ctrl_reg_tb.sv
module tmr_ctrl_reg_tb_top;
    localparam int CLK_P  = 10;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [CNT_W-1:0]  mod_val = '0;
    logic [CNT_W-1:0]  cnt_o;
    logic              irq_o, dma_req_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_ctrl_reg #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_val(mod_val), .cnt_o(cnt_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // word builder: dma bit 8, flag bit 7, ie bit 6, mode 4:3, prescale 2:0
    function automatic logic [31:0] mk(input bit dma, input bit clr, input bit ie,
                                       input logic [1:0] cm, input logic [2:0] ps);
        mk = '0;
        mk[8] = dma; mk[7] = clr; mk[6] = ie; mk[4:3] = cm; mk[2:0] = ps;
    endfunction

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_addr = '0;
    endtask

    task automatic clean();
        for (int i = 0; i < 3; i++) bus_write('0, mk(0, 1, 0, 2'd0, 3'd0));
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read('0, r);
        check("R1 word", r, 32'h0);
        check("R1 cnt", 32'(cnt_o), 32'h0);
        check("R1 irq/dma", {30'h0, irq_o, dma_req_o}, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] r;
        bus_write('0, 32'hFFFF_FF67 & ~32'h0000_0080 & ~32'h18);
        bus_read('0, r);
        check("R3 R2 fields dma ie ps", r, mk(1, 0, 1, 2'd0, 3'd7));
        bus_write('0, mk(0, 0, 0, 2'd0, 3'd5) | 32'h0000_0020);
        bus_read('0, r);
        check("R3 R2 ps readback rsv5", r, mk(0, 0, 0, 2'd0, 3'd5));
        clean();
    endtask

    task automatic t_offset();
        logic [31:0] r;
        bus_write('0, mk(1, 0, 0, 2'd0, 3'd2));
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_read('0, r);
        check("R12 offset write ignored", r, mk(1, 0, 0, 2'd0, 3'd2));
        bus_read(4'd1, r);
        check("R12 offset reads zero", r, 32'h0);
        clean();
    endtask

    task automatic t_stop_run();
        logic [CNT_W-1:0] c0;
        mod_val = 16'd1000;
        c0 = cnt_o;
        repeat (10) @(negedge clk);
        check("R4 stopped holds", 32'(cnt_o), 32'(c0));
        bus_write('0, mk(0, 0, 0, 2'd2, 3'd0));
        c0 = cnt_o;
        repeat (5) @(negedge clk);
        check("R4 running advances", 32'(cnt_o), 32'(c0 + 16'd5));
        clean();
    endtask

    task automatic t_prescale(input logic [2:0] ps, input logic [CNT_W-1:0] m);
        logic [CNT_W-1:0] prev;
        int t = 0, t1 = -1, t2 = -1;
        mod_val = m;
        bus_write('0, mk(0, 0, 0, 2'd1, ps));
        prev = cnt_o;
        while (t2 < 0 && t < 5000) begin
            @(negedge clk);
            t++;
            if (cnt_o == '0 && prev != '0) begin
                if (t1 < 0) t1 = t; else t2 = t;
            end
            prev = cnt_o;
        end
        check("R5 wrap interval", 32'(t2 - t1), 32'((int'(m) + 1) << ps));
        clean();
    endtask

    task automatic t_flag_basic();
        logic [31:0] r;
        logic [CNT_W-1:0] prev;
        bit seen = 0;
        mod_val = 16'd5;
        bus_write('0, mk(1, 0, 1, 2'd1, 3'd0));
        prev = cnt_o;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (cnt_o == '0 && prev != '0) seen = 1;
            else prev = cnt_o;
        end
        bus_read('0, r);
        check("R6 flag set at wrap", {31'h0, r[7]}, 32'h1);
        check("R10 R11 requests high", {30'h0, irq_o, dma_req_o}, 32'h3);
        bus_write('0, mk(1, 0, 1, 2'd0, 3'd0));
        bus_write('0, mk(0, 0, 1, 2'd0, 3'd0));
        check("R11 dma off", {31'h0, dma_req_o}, 32'h0);
        check("R10 irq on", {31'h0, irq_o}, 32'h1);
        bus_write('0, mk(1, 0, 0, 2'd0, 3'd0));
        check("R10 irq off", {31'h0, irq_o}, 32'h0);
        bus_read('0, r);
        check("R7 write zero keeps flag", {31'h0, r[7]}, 32'h1);
        bus_write('0, mk(1, 1, 0, 2'd0, 3'd0));
        bus_read('0, r);
        check("R7 write one clears flag", {31'h0, r[7]}, 32'h0);
        check("R11 dma low after clear", {31'h0, dma_req_o}, 32'h0);
        clean();
    endtask

    task automatic t_reovf();
        logic [31:0] r;
        mod_val = 16'd0;
        bus_write('0, mk(0, 0, 0, 2'd1, 3'd0));
        repeat (3) @(negedge clk);
        bus_write('0, mk(0, 0, 0, 2'd0, 3'd0));
        bus_write('0, mk(0, 1, 0, 2'd0, 3'd0));
        bus_read('0, r);
        check("R8 first clear absorbed", {31'h0, r[7]}, 32'h1);
        bus_write('0, mk(0, 1, 0, 2'd0, 3'd0));
        bus_read('0, r);
        check("R8 second clear clears", {31'h0, r[7]}, 32'h0);
        clean();
    endtask

    task automatic t_collision();
        logic [31:0] r;
        int g = 0;
        mod_val = 16'd3;
        bus_write('0, mk(0, 0, 1, 2'd1, 3'd0));
        while (!irq_o && g < 100) begin @(negedge clk); g++; end
        while (cnt_o != 16'd3 && g < 200) begin @(negedge clk); g++; end
        bus_write('0, mk(0, 1, 1, 2'd1, 3'd0));
        bus_read('0, r);
        check("R9 set wins over clear", {31'h0, r[7]}, 32'h1);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_offset();
        t_stop_run();
        t_prescale(3'd0, 16'd2);
        t_prescale(3'd2, 16'd2);
        t_prescale(3'd7, 16'd1);
        t_flag_basic();
        t_reovf();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule